// File: doc/BRIEF.md
# Guarded RAM Self-Test Control Registers

This block holds the two controls that an external memory test path needs: a one-bit test enable and a three-bit page select. Software reaches both through a small synchronous register port. A write happens in the cycle where the write strobe is high. Read data is a combinational function of the address.

Two guards protect the controls. Both registers accept writes only while the 2-bit chip mode input reads binary 10, the test mode. The enable register has a second guard, a key register. The enable cannot change until software has written the word 7575h and then the word 8A8Ah to the key register, with no other register write between the two. When the mode moves away from 10b, the protection locks again and the enable drops to 0.

Top module: `ramtest_guard`

## Requirements
- R1: After reset, test_en_o is 0, test_page_o is 0, and a read of any address returns 0000h.
- R2: While mode_i is not 10b, writes to the page register (address 0) and to the enable register (address 1) leave both outputs and their readback unchanged.
- R3: In mode 10b, once the key register (address 2) has taken 7575h and then 8A8Ah on consecutive register writes, a write to address 1 copies write-data bit 2 into the enable. A read of address 1 then returns the enable at bit 2.
- R4: A write to address 1 made before the unlock sequence completes does not change the enable.
- R5: The unlock sequence restarts in three cases: a key write of any value other than the expected next key, a write to address 0 or 1 between the two keys, or 8A8Ah written without a preceding 7575h.
- R6: In mode 10b, a write to address 0 whose bits 10:8 hold 0, 1 or 2 loads that value into the page. A read of address 0 returns the page at bits 10:8.
- R7: A page write whose bits 10:8 hold 3 to 7 is rejected and the previous page is kept.
- R8: Reserved bits read as 0. For address 0 these are all bits except 10:8. For address 1 they are all bits except bit 2. Addresses 2 and 3 read as 0 in full.
- R9: A cycle with mode_i other than 10b clears the enable and locks the protection again, so a new key sequence is needed.
- R10: test_en_o and test_page_o are registered. They change at the rising clock edge that ends the cycle of the accepted write.
- R11: While unlocked, the enable can be written to 0 and back to 1 repeatedly without a new key sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Chip mode; 10b is test mode |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 page, 1 enable, 2 key |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| test_en_o | output | 1 | Memory test enable |
| test_page_o | output | 3 | Memory test page number |

## Verification
Read data is due in the same cycle the address is presented. The two outputs, and the readback that reflects them, are due one rising edge after an accepted write. The bench drives every input on the falling edge and compares rdata_o 1 ns later against its model's values from before the edge. It then lets the model take the same write at the rising edge and compares the registered outputs at the next falling edge. A rejected write is therefore seen as an output that did not move when it would otherwise have moved.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int          DW         = 16;
  localparam int          PAGE_W     = 3;
  localparam int          PAGE_LSB   = 8;
  localparam int          EN_BIT     = 2;
  localparam int          PAGE_LIMIT = 2;
  localparam logic [1:0]  MODE_TEST  = 2'b10;
  localparam logic [15:0] KEY_FIRST  = 16'h7575;
  localparam logic [15:0] KEY_SECOND = 16'h8A8A;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_e;

  function automatic logic page_legal(input logic [PAGE_W-1:0] p);
    return int'(p) <= PAGE_LIMIT;
  endfunction

  function automatic logic [DW-1:0] cfg_image(input logic [PAGE_W-1:0] p);
    logic [DW-1:0] w;
    w = '0;
    w[PAGE_LSB +: PAGE_W] = p;
    return w;
  endfunction

  function automatic logic [DW-1:0] ctl_image(input logic en);
    logic [DW-1:0] w;
    w = '0;
    w[EN_BIT] = en;
    return w;
  endfunction
endpackage

// File: rtl/rtg_keyseq.sv
module rtg_keyseq
  import rtg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_test,
  input  logic          key_wr,
  input  logic [DW-1:0] key_data,
  input  logic          other_wr,
  output logic          unlocked_o
);
  key_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!in_test) begin
      st_d = KS_LOCKED;
    end else if (key_wr) begin
      if (key_data == KEY_FIRST)
        st_d = KS_HALF;
      else if (key_data == KEY_SECOND && st_q == KS_HALF)
        st_d = KS_OPEN;
      else
        st_d = KS_LOCKED;
    end else if (other_wr && st_q == KS_HALF) begin
      st_d = KS_LOCKED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KS_LOCKED;
    else        st_q <= st_d;
  end

  assign unlocked_o = (st_q == KS_OPEN);
endmodule

// File: rtl/rtg_fields.sv
module rtg_fields
  import rtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_test,
  input  logic              cfg_wr,
  input  logic              ctl_wr,
  input  logic              unlocked,
  input  logic [PAGE_W-1:0] page_in,
  input  logic              en_in,
  output logic              en_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              cfg_take_o,
  output logic              ctl_take_o
);
  assign cfg_take_o = in_test & cfg_wr & page_legal(page_in);
  assign ctl_take_o = in_test & ctl_wr & unlocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          en_o <= 1'b0;
    else if (!in_test)   en_o <= 1'b0;
    else if (ctl_take_o) en_o <= en_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          page_o <= '0;
    else if (cfg_take_o) page_o <= page_in;
  end
endmodule

// File: rtl/rtg_readmux.sv
module rtg_readmux
  import rtg_pkg::*;
#(
  parameter int AW       = 2,
  parameter int CFG_ADDR = 0,
  parameter int CTL_ADDR = 1
) (
  input  logic [AW-1:0]     addr,
  input  logic [PAGE_W-1:0] page,
  input  logic              en,
  output logic [DW-1:0]     rdata
);
  localparam logic [AW-1:0] A_CFG = AW'(CFG_ADDR);
  localparam logic [AW-1:0] A_CTL = AW'(CTL_ADDR);

  always_comb begin
    if (addr == A_CFG)      rdata = cfg_image(page);
    else if (addr == A_CTL) rdata = ctl_image(en);
    else                    rdata = '0;
  end
endmodule

// File: rtl/ramtest_guard.sv
module ramtest_guard
  import rtg_pkg::*;
#(
  parameter int AW       = 2,
  parameter int CFG_ADDR = 0,
  parameter int CTL_ADDR = 1,
  parameter int KEY_ADDR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  output logic              test_en_o,
  output logic [2:0]        test_page_o
);
  localparam logic [AW-1:0] A_CFG = AW'(CFG_ADDR);
  localparam logic [AW-1:0] A_CTL = AW'(CTL_ADDR);
  localparam logic [AW-1:0] A_KEY = AW'(KEY_ADDR);

  logic in_test_w, cfg_wr_w, ctl_wr_w, key_wr_w;
  logic unlocked_w, cfg_take_w, ctl_take_w;

  assign in_test_w = (mode_i == MODE_TEST);
  assign cfg_wr_w  = wr_en_i && (addr_i == A_CFG);
  assign ctl_wr_w  = wr_en_i && (addr_i == A_CTL);
  assign key_wr_w  = wr_en_i && (addr_i == A_KEY);

  rtg_keyseq u_keyseq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_test   (in_test_w),
    .key_wr    (key_wr_w),
    .key_data  (wdata_i),
    .other_wr  (cfg_wr_w | ctl_wr_w),
    .unlocked_o(unlocked_w)
  );

  rtg_fields u_fields (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_test   (in_test_w),
    .cfg_wr    (cfg_wr_w),
    .ctl_wr    (ctl_wr_w),
    .unlocked  (unlocked_w),
    .page_in   (wdata_i[PAGE_LSB +: PAGE_W]),
    .en_in     (wdata_i[EN_BIT]),
    .en_o      (test_en_o),
    .page_o    (test_page_o),
    .cfg_take_o(cfg_take_w),
    .ctl_take_o(ctl_take_w)
  );

  rtg_readmux #(
    .AW      (AW),
    .CFG_ADDR(CFG_ADDR),
    .CTL_ADDR(CTL_ADDR)
  ) u_readmux (
    .addr (addr_i),
    .page (test_page_o),
    .en   (test_en_o),
    .rdata(rdata_o)
  );
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker #(
  parameter int AW       = 2,
  parameter int KEY_ADDR = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode_i,
  input logic          wr_en_i,
  input logic [AW-1:0] addr_i,
  input logic [15:0]   wdata_i,
  input logic [15:0]   rdata_o,
  input logic          test_en_o,
  input logic [2:0]    test_page_o,
  input logic          unlocked,
  input logic          cfg_take,
  input logic          ctl_take
);
  localparam logic [AW-1:0] A_KEY = AW'(KEY_ADDR);

  assert_leave_mode_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != 2'b10) |=> !test_en_o);

  assert_page_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    test_page_o <= 3'd2);

  assert_enable_rise_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_en_o) |-> $past(ctl_take));

  assert_unlock_after_second_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(wr_en_i && addr_i == A_KEY && wdata_i == 16'h8A8A));

  assert_page_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_take |=> $stable(test_page_o));

  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_o & 16'hF8FB) == 16'h0000);

  assert_enable_follows_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_take |=> test_en_o == $past(wdata_i[2]));
endmodule

bind ramtest_guard rtg_checker #(.AW(AW), .KEY_ADDR(KEY_ADDR)) u_rtg_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_i     (mode_i),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .test_en_o  (test_en_o),
  .test_page_o(test_page_o),
  .unlocked   (unlocked_w),
  .cfg_take   (cfg_take_w),
  .ctl_take   (ctl_take_w)
);

// File: tb/test_ramtest_guard.sv
`timescale 1ns/1ps
module test_ramtest_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        wr = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'h0000;
  logic [15:0] rdata;
  logic        ten;
  logic [2:0]  tpage;

  int vecs = 0;
  int miss = 0;

  // reference model state: 0 locked, 1 first key seen, 2 open
  int m_key = 0;
  int m_en = 0;
  int m_page = 0;

  always #4 clk = ~clk;

  ramtest_guard i_ramtest_guard (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .wr_en_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .test_en_o(ten), .test_page_o(tpage)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int model_read(input int a);
    if (a == 0) return m_page * 256;
    if (a == 1) return m_en * 4;
    return 0;
  endfunction

  task automatic model_edge(input int m, input bit we, input int a, input int d);
    if (m != 2) begin
      m_key = 0;
      m_en = 0;
    end else if (we) begin
      if (a == 2) begin
        if (d == 'h7575) m_key = 1;
        else if (d == 'h8A8A && m_key == 1) m_key = 2;
        else m_key = 0;
      end else if (a == 0) begin
        if (m_key == 1) m_key = 0;
        if (((d / 256) % 8) < 3) m_page = (d / 256) % 8;
      end else if (a == 1) begin
        if (m_key == 2) m_en = (d / 4) % 2;
        if (m_key == 1) m_key = 0;
      end
    end
  endtask

  // one bus cycle: drive at falling edge, check read data, clock, check outputs
  task automatic step(input int m, input bit we, input int a, input int d, input string tag);
    mode = m[1:0]; wr = we; addr = a[1:0]; wdata = d[15:0];
    #1;
    chk(tag, "rdata", int'(rdata), model_read(a));
    @(posedge clk);
    model_edge(m, we, a, d);
    @(negedge clk);
    chk(tag, "test_en", int'(ten), m_en);
    chk(tag, "test_page", int'(tpage), m_page);
  endtask

  task automatic unlock(input string tag);
    step(2, 1, 2, 'h7575, tag);
    step(2, 1, 2, 'h8A8A, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "test_en", int'(ten), 0);
    chk("R1", "test_page", int'(tpage), 0);
    for (int a = 0; a < 4; a++) step(0, 0, a, 0, "R1");

    // R2 writes ignored outside test mode
    step(0, 1, 0, 'h0200, "R2");
    step(1, 1, 0, 'h0100, "R2");
    step(3, 1, 1, 'h0004, "R2");
    step(1, 1, 2, 'h7575, "R2");
    step(1, 1, 2, 'h8A8A, "R2");
    step(2, 1, 1, 'h0004, "R2");
    step(2, 0, 0, 0, "R2");

    // R4 no unlock, enable write ignored
    step(2, 1, 1, 'h0004, "R4");
    step(2, 0, 1, 0, "R4");

    // R6 / R7 / R8 page field
    step(2, 1, 0, 'h0100, "R6");
    step(2, 0, 0, 0, "R6");
    step(2, 1, 0, 'h0300, "R7");
    step(2, 1, 0, 'hFFFF, "R7");
    step(2, 1, 0, 'h0200, "R6");
    step(2, 1, 0, 'hF8FF, "R8");
    step(2, 0, 0, 0, "R8");
    step(2, 1, 0, 'hFAFF, "R8");
    step(2, 0, 0, 0, "R8");

    // R5 broken key sequences
    step(2, 1, 2, 'h7575, "R5");
    step(2, 1, 0, 'h0100, "R5");
    step(2, 1, 2, 'h8A8A, "R5");
    step(2, 1, 1, 'h0004, "R5");
    step(2, 1, 2, 'h7575, "R5");
    step(2, 1, 2, 'h1234, "R5");
    step(2, 1, 2, 'h8A8A, "R5");
    step(2, 1, 1, 'h0004, "R5");
    step(2, 1, 2, 'h8A8A, "R5");
    step(2, 1, 2, 'h7575, "R5");
    step(2, 1, 1, 'h0004, "R5");
    step(2, 1, 2, 'h7575, "R5");
    step(2, 1, 1, 'h0000, "R5");
    step(2, 1, 2, 'h8A8A, "R5");
    step(2, 1, 1, 'h0004, "R5");

    // R3 / R10 unlock then set enable
    unlock("R3");
    step(2, 1, 1, 'hFFFF, "R10");
    step(2, 0, 1, 0, "R3");
    step(2, 0, 3, 0, "R8");
    step(2, 0, 2, 0, "R8");

    // R11 toggling while unlocked
    step(2, 1, 1, 'h0000, "R11");
    step(2, 1, 1, 'h0004, "R11");
    step(2, 1, 0, 'h0100, "R11");
    step(2, 1, 1, 'h0000, "R11");
    step(2, 1, 1, 'h0004, "R11");
    step(2, 0, 1, 0, "R11");

    // R9 leaving test mode relocks and clears
    step(0, 0, 1, 0, "R9");
    step(2, 1, 1, 'h0004, "R9");
    step(2, 0, 1, 0, "R9");
    unlock("R9");
    step(2, 1, 1, 'h0004, "R9");
    step(3, 1, 1, 'h0004, "R9");
    step(2, 0, 0, 0, "R9");

    // R1 reset mid-run returns to reset state and locks
    unlock("R1");
    step(2, 1, 1, 'h0004, "R1");
    rst_n = 1'b0;
    #1;
    m_key = 0; m_en = 0; m_page = 0;
    chk("R1", "test_en", int'(ten), 0);
    chk("R1", "test_page", int'(tpage), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    step(2, 1, 1, 'h0004, "R1");
    step(2, 0, 0, 0, "R1");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    vecs++;
    miss++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule